// File: doc/BRIEF.md
# Two-Way Set-Associative Tag Lookup with LRU Replacement

This block is the tag and replacement half of a two-way set-associative cache. A request presents a block address. The low address bits select one set out of `SETS`, and the rest of the address forms the tag. That tag is compared against both ways of the selected set at the same time. The hit or miss result, the way that hit and the way that would be replaced are all produced combinationally in the request cycle.

A surrounding controller owns the data array, the memory side and the write policy, and it uses these outputs to steer them. When a request misses with the fill flag set, the block installs the tag in the chosen victim way on the next clock edge. The victim is an empty way when the set has one. When both ways are occupied, the victim is the way used less recently. One bit per set records which way that is.

Top module: `tlk_lookup`

## Requirements
- R1: After reset every way of every set is empty. The first lookup of any address misses, reports victim way 0 and does not flag an eviction.
- R2: The set is the block address modulo `SETS`, which is its low `log2(SETS)` bits. The tag is the remaining upper bits. The same tag in a different set never hits.
- R3: A valid request hits when a valid way of the selected set holds a matching tag. `hitWay` names that way (0 or 1) and is 0 on a miss.
- R4: On a miss in a set that still has an empty way, the victim is the lowest-numbered empty way and `evict` stays 0.
- R5: On a miss in a full set, the victim is the least recently used way. `evict` is 1 and `evictTag` carries the tag held in that way.
- R6: Every hit and every fill marks the way just used as most recent, so that the set's replacement choice points at the other way from the next cycle on.
- R7: A miss without the fill flag only reports. Tags, valid bits and recency are left unchanged.
- R8: Results reflect the state before the clock edge that ends the request. A tag filled in one cycle hits from the following cycle, in the way that was reported as the victim.
- R9: With two sets, the block-address sequence 0, 8, 0, 6, 8 (all filled on miss) gives miss, miss, hit, miss, miss. A direct-mapped arrangement of the same four lines misses on all five.
- R10: With `reqValid` low, `hit` and `evict` stay 0 and no state changes, even if `reqFill` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A lookup is presented this cycle |
| reqAddr | input | ADDR_W | Block address of the lookup |
| reqFill | input | 1 | Install the tag if the lookup misses |
| hit | output | 1 | Tag found in the selected set |
| hitWay | output | 1 | Way that hit (0 on miss) |
| victimWay | output | 1 | Way chosen for replacement in the selected set |
| evict | output | 1 | Miss whose victim way holds a valid tag |
| evictTag | output | ADDR_W-log2(SETS) | Tag in the victim way when `evict` is 1, else 0 |

## Verification
A fill and a lookup of the same address can meet on one clock edge. The request that installs a tag still reports a miss, because its result comes from the old state. A lookup of that address in the next cycle has to hit in the way that was named as victim. The bench provokes this by issuing a filling miss and then, in the next cycle, a lookup of the same address. It judges the hit flag and the way of both lookups. The same collision also occurs between a hit's recency update and the next miss's victim choice. Back-to-back requests to one set check that the victim points away from the way that was just hit.

// File: rtl/tlk_pkg.sv
package tlk_pkg;
  // Strobes from control to datapath for the set addressed this cycle.
  typedef struct packed {
    logic touch;  // update recency: the other way becomes the replacement choice
    logic fill;   // write tag and set valid in 'way'
    logic way;    // way being touched or filled
  } tlk_strobe_t;
endpackage

// File: rtl/tlk_datapath.sv
module tlk_datapath
  import tlk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SETS   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  tlk_strobe_t              strobe,
  input  logic                     victimWay,
  output logic [1:0]               tagMatch,
  output logic [1:0]               wayValid,
  output logic                     setLru,
  output logic [ADDR_W-$clog2(SETS)-1:0] victimTag
);
  localparam int WAYS  = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] setIdx;
  logic [TAG_W-1:0] reqTag;
  logic [WAYS-1:0][TAG_W-1:0] wayTag;
  logic [SETS-1:0] lruArr;

  // SETS is a power of two, so the modulo is the low address bits.
  assign setIdx = reqAddr[IDX_W-1:0];
  assign reqTag = reqAddr[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tagArr [SETS];
    logic [SETS-1:0]  vldArr;
    logic             wrThis;

    assign wrThis = strobe.fill && (strobe.way == 1'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) vldArr <= '0;
      else if (wrThis) vldArr[setIdx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wrThis) tagArr[setIdx] <= reqTag;
    end

    assign wayValid[w] = vldArr[setIdx];
    assign wayTag[w]   = tagArr[setIdx];
    assign tagMatch[w] = vldArr[setIdx] && (tagArr[setIdx] == reqTag);
  end

  // One bit per set: the way to replace when both ways are valid.
  always_ff @(posedge clk) begin
    if (!rst_n) lruArr <= '0;
    else if (strobe.touch) lruArr[setIdx] <= ~strobe.way;
  end

  assign setLru    = lruArr[setIdx];
  assign victimTag = wayTag[victimWay];
endmodule

// File: rtl/tlk_control.sv
module tlk_control
  import tlk_pkg::*;
(
  input  logic        reqValid,
  input  logic        reqFill,
  input  logic [1:0]  tagMatch,
  input  logic [1:0]  wayValid,
  input  logic        setLru,
  output logic        hit,
  output logic        hitWay,
  output logic        victimWay,
  output logic        evict,
  output tlk_strobe_t strobe
);
  logic anyMatch;
  logic missReq;

  assign anyMatch = |tagMatch;
  assign hit      = reqValid && anyMatch;
  assign hitWay   = reqValid && tagMatch[1];
  assign missReq  = reqValid && !anyMatch;

  // Empty ways first, lowest index wins; otherwise the recency bit decides.
  always_comb begin
    if (!wayValid[0])      victimWay = 1'b0;
    else if (!wayValid[1]) victimWay = 1'b1;
    else                   victimWay = setLru;
  end

  assign evict = missReq && (&wayValid);

  always_comb begin
    strobe.fill  = missReq && reqFill;
    strobe.touch = hit || strobe.fill;
    strobe.way   = hit ? hitWay : victimWay;
  end
endmodule

// File: rtl/tlk_lookup.sv
module tlk_lookup
  import tlk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SETS   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reqValid,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic                           reqFill,
  output logic                           hit,
  output logic                           hitWay,
  output logic                           victimWay,
  output logic                           evict,
  output logic [ADDR_W-$clog2(SETS)-1:0] evictTag
);
  localparam int TAG_W = ADDR_W - $clog2(SETS);

  tlk_strobe_t      strobe;
  logic [1:0]       tagMatch;
  logic [1:0]       wayValid;
  logic             setLru;
  logic [TAG_W-1:0] victimTag;

  tlk_datapath #(.ADDR_W(ADDR_W), .SETS(SETS)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqAddr   (reqAddr),
    .strobe    (strobe),
    .victimWay (victimWay),
    .tagMatch  (tagMatch),
    .wayValid  (wayValid),
    .setLru    (setLru),
    .victimTag (victimTag)
  );

  tlk_control ctl_i (
    .reqValid  (reqValid),
    .reqFill   (reqFill),
    .tagMatch  (tagMatch),
    .wayValid  (wayValid),
    .setLru    (setLru),
    .hit       (hit),
    .hitWay    (hitWay),
    .victimWay (victimWay),
    .evict     (evict),
    .strobe    (strobe)
  );

  assign evictTag = evict ? victimTag : '0;
endmodule

// File: rtl/tlk_checker.sv
module tlk_checker #(
  parameter int ADDR_W = 8,
  parameter int SETS   = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           reqValid,
  input logic [ADDR_W-1:0]              reqAddr,
  input logic                           reqFill,
  input logic                           hit,
  input logic                           hitWay,
  input logic                           victimWay,
  input logic                           evict,
  input logic [ADDR_W-$clog2(SETS)-1:0] evictTag
);
  // R10: idle cycles report nothing
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |-> (!hit && !evict));

  // R5: an eviction only happens on a miss
  assert_evict_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evict |-> !hit);

  // R3: no way index reported without a hit
  assert_way_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !hit) |-> !hitWay);

  // R7: a non-filling miss leaves the address missing
  assert_nofill_keeps_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && $past(reqValid && !reqFill && !hit) && reqAddr == $past(reqAddr)) |-> !hit);

  // R8: a filled tag hits in the next cycle, in the reported victim way
  assert_fill_then_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && $past(reqValid && reqFill && !hit) && reqAddr == $past(reqAddr))
      |-> (hit && hitWay == $past(victimWay)));

  // R6: after a hit the replacement choice for that set is the other way
  assert_hit_moves_lru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && $past(reqValid && hit) && reqAddr == $past(reqAddr))
      |-> (victimWay != $past(hitWay)));
endmodule

bind tlk_lookup tlk_checker #(.ADDR_W(ADDR_W), .SETS(SETS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .reqFill   (reqFill),
  .hit       (hit),
  .hitWay    (hitWay),
  .victimWay (victimWay),
  .evict     (evict),
  .evictTag  (evictTag)
);

// File: tb/tlk_lookup_tb_top.sv
module tlk_lookup_tb_top;
  localparam int ADDR_W = 8;
  localparam int SETS   = 2;
  localparam int TAG_W  = ADDR_W - $clog2(SETS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqFill = 1'b0;
  logic hit, hitWay, victimWay, evict;
  logic [TAG_W-1:0] evictTag;

  int nChecks = 0;
  int nFail = 0;

  logic rHit, rWay, rVic, rEv;
  logic [TAG_W-1:0] rTag;

  always #2 clk = ~clk;  // 4 ns period

  tlk_lookup #(.ADDR_W(ADDR_W), .SETS(SETS)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqFill(reqFill), .hit(hit), .hitWay(hitWay), .victimWay(victimWay),
    .evict(evict), .evictTag(evictTag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reqValid = 1'b0; reqFill = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Present one request at a falling edge and sample the combinational result.
  task automatic look(input int a, input logic f);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = ADDR_W'(a); reqFill = f;
    #1;
    rHit = hit; rWay = hitWay; rVic = victimWay; rEv = evict; rTag = evictTag;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0; reqFill = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 idle hit after reset", int'(hit), 0);
    look(5, 1'b0);
    chk("R1 first lookup hit", int'(rHit), 0);
    chk("R1 first victim", int'(rVic), 0);
    chk("R1 first evict", int'(rEv), 0);
    idle();
  endtask

  task automatic t_trace();
    int addrs[5] = '{0, 8, 0, 6, 8};
    int expHit[5] = '{0, 0, 1, 0, 0};
    do_reset();
    for (int i = 0; i < 5; i++) begin
      look(addrs[i], 1'b1);
      chk($sformatf("R9 trace step %0d hit", i), int'(rHit), expHit[i]);
      if (i == 3) begin
        chk("R5 trace step 3 victim", int'(rVic), 1);
        chk("R5 trace step 3 evictTag", int'(rTag), 4);
      end
      if (i == 4) begin
        chk("R5 trace step 4 victim", int'(rVic), 0);
        chk("R5 trace step 4 evictTag", int'(rTag), 0);
      end
    end
    idle();
  endtask

  task automatic t_set_index();
    do_reset();
    look(3, 1'b1);            // set 1, tag 1
    look(2, 1'b0);            // set 0, tag 1
    chk("R2 same tag other set", int'(rHit), 0);
    look(1, 1'b0);            // set 1, tag 0
    chk("R2 other tag same set", int'(rHit), 0);
    look(3, 1'b0);
    chk("R3 hit after fill", int'(rHit), 1);
    chk("R3 hit way", int'(rWay), 0);
    idle();
  endtask

  task automatic t_invalid_first();
    do_reset();
    look(4, 1'b1);            // set 0 way 0
    look(10, 1'b0);           // set 0 miss
    chk("R4 empty way chosen", int'(rVic), 1);
    chk("R4 no evict with empty way", int'(rEv), 0);
    look(10, 1'b1);
    look(10, 1'b0);
    chk("R3 hit in way 1", int'(rHit), 1);
    chk("R3 hit way index 1", int'(rWay), 1);
    idle();
  endtask

  task automatic t_nofill_and_lru();
    do_reset();
    look(0, 1'b1);            // way 0, tag 0
    look(2, 1'b1);            // way 1, tag 1; replacement now points at way 0
    look(4, 1'b0);
    chk("R5 full set victim", int'(rVic), 0);
    chk("R5 full set evict", int'(rEv), 1);
    chk("R5 full set evictTag", int'(rTag), 0);
    look(4, 1'b0);
    chk("R7 still miss", int'(rHit), 0);
    chk("R7 victim unchanged", int'(rVic), 0);
    look(0, 1'b0);
    chk("R7 way 0 kept", int'(rHit), 1);
    idle();
    look(4, 1'b0);
    chk("R6 victim after hit way 0", int'(rVic), 1);
    chk("R6 evictTag after hit way 0", int'(rTag), 1);
    look(2, 1'b0);
    chk("R7 way 1 kept", int'(rHit), 1);
    idle();
    look(4, 1'b0);
    chk("R6 victim after hit way 1", int'(rVic), 0);
    idle();
  endtask

  task automatic t_same_cycle();
    do_reset();
    look(6, 1'b1);
    chk("R8 filling request misses", int'(rHit), 0);
    chk("R8 filling victim", int'(rVic), 0);
    look(6, 1'b0);
    chk("R8 next cycle hit", int'(rHit), 1);
    chk("R8 next cycle way", int'(rWay), 0);
    idle();
  endtask

  task automatic t_idle();
    do_reset();
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 8'd6; reqFill = 1'b1;
    @(negedge clk);
    look(6, 1'b0);
    chk("R10 idle fill ignored", int'(rHit), 0);
    look(6, 1'b1);
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 8'd6; reqFill = 1'b0;
    #1;
    chk("R10 hit low when idle", int'(hit), 0);
    chk("R10 evict low when idle", int'(evict), 0);
  endtask

  initial begin
    t_reset();
    t_trace();
    t_set_index();
    t_invalid_first();
    t_nofill_and_lru();
    t_same_cycle();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule